// File: doc/BRIEF.md
# Interrupt Status and Card-Detect Register

This block holds one 32-bit control word for a removable-card host. The low half carries status and event flags. The high half carries the enable for each flag, at the flag's position plus 16. Two flags are live levels: card presence and FIFO-empty. The event flags are card insertion, card removal, DMA done and DMA/IO error. They latch when their cause occurs and stay set until software writes a zero to them. Bit 15 drives an activity LED.

The card-present pin is asynchronous. It passes through a two-flop synchroniser before any logic uses it. An insertion or removal event is recorded only on the matching edge of the synchronised level, and only while that event's detect enable is set. This lets software arm exactly one direction at a time. A single interrupt line is raised while any of bits 8 to 14 is set together with its enable.

Top module: `card_irq_reg`

## Requirements
- R1: After a synchronous active-low reset, the whole register reads 0x00000000 and both `irq` and `led_on` are low.
- R2: Bit 1 is read-only and shows `card_present` after two clock edges of synchronisation.
- R3: Bit 8 (insert) is set in the same cycle that bit 1 rises, provided enable bit 24 was set before that edge.
- R4: Bit 9 (remove) is set in the same cycle that bit 1 falls, provided enable bit 25 was set before that edge.
- R5: A one-cycle `dma_done` pulse sets bit 11, and a one-cycle `dma_err` pulse sets bit 14. Both are recorded whatever their enables hold.
- R6: Bit 10 is read-only and follows `fifo_empty` with no delay.
- R7: On a write, each event bit in 8, 9, 11, 14 and 15 is cleared where the written bit is 0 and left unchanged where it is 1. Writes do not affect bits 1 and 10.
- R8: If a new event arrives in the same cycle as a write that clears its bit, the bit ends up set.
- R9: A write loads bits 30:24 straight from the written data. Bits 31 and 23:16 always read 0, as do bits 0, 7:2, 12 and 13.
- R10: `irq` is high exactly when any of bits 8 to 14 is set together with its enable at the same position plus 16.
- R11: A `led_set` pulse sets bit 15. Writing 0 to bit 15 clears it. `led_on` equals bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| card_present | input | 1 | Asynchronous card-present pin |
| dma_done | input | 1 | DMA completion pulse |
| dma_err | input | 1 | DMA or IO error pulse |
| fifo_empty | input | 1 | FIFO-empty level |
| led_set | input | 1 | Pulse that turns the activity LED on |
| irq | output | 1 | Level interrupt |
| led_on | output | 1 | Activity LED drive |

## Verification
The bench drives the card pin through several patterns:
- Slow insert and remove cycles with only one direction armed. These show that each edge latches only its own flag.
- The same edges with detection disarmed. These show the enable gate.
- Writes that mix ones and zeros. These separate write-zero-to-clear from plain loading.
- DMA pulses placed in the same cycle as a clearing write. These expose set-versus-clear priority.

A long random phase then mixes all inputs. The interrupt line is compared every cycle against masks that change underneath latched flags.

// File: rtl/card_irq_pkg.sv
// Bit positions and widths shared by the card interrupt register.
// Assumes the 32-bit word layout: status low half, enables high half.
package card_irq_pkg;
    localparam int WORD_W     = 32;
    localparam int EN_SHIFT   = 16;
    localparam int POS_PRES   = 1;
    localparam int POS_INS    = 8;
    localparam int POS_REM    = 9;
    localparam int POS_FIFO   = 10;
    localparam int POS_DONE   = 11;
    localparam int POS_ERR    = 14;
    localparam int POS_LED    = 15;
    localparam int IRQ_LO     = 8;
    localparam int IRQ_HI     = 14;
    localparam int IRQ_W      = IRQ_HI - IRQ_LO + 1;
    localparam int N_LATCH    = 5;
    // Order of latched flags inside the latch bank
    localparam int L_INS  = 0;
    localparam int L_REM  = 1;
    localparam int L_DONE = 2;
    localparam int L_ERR  = 3;
    localparam int L_LED  = 4;
endpackage

// File: rtl/cdet_sync.sv
// Synchroniser for the asynchronous card-present pin with edge outputs.
// Assumes STAGES >= 2; rise/fall are valid in the cycle before the level updates.
module cdet_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sh;

    // Shift the pin through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], pin};
    end

    assign level = sh[STAGES-1];
    assign rise  = sh[STAGES-2] & ~sh[STAGES-1];
    assign fall  = ~sh[STAGES-2] & sh[STAGES-1];
endmodule

// File: rtl/evt_latch.sv
// Bank of sticky flags: set by an event, cleared when keep is low.
// Assumes set dominates clear within a cycle.
module evt_latch #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] keep,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_flag
        // One sticky flag: event sets, zero-write clears
        always_ff @(posedge clk) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= set[i] | (q[i] & keep[i]);
        end
    end
endmodule

// File: rtl/card_irq_reg.sv
// Interrupt status/enable register with card-detect event tracking.
// Assumes single-register access: wr_en selects this word, rd_data is always valid.
module card_irq_reg
    import card_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              card_present,
    input  logic              dma_done,
    input  logic              dma_err,
    input  logic              fifo_empty,
    input  logic              led_set,
    output logic              irq,
    output logic              led_on
);
    logic               pres_lvl, pres_rise, pres_fall;
    logic [IRQ_W-1:0]   en_q;
    logic [N_LATCH-1:0] set_v, keep_v, flag_q;
    logic [IRQ_W-1:0]   stat_v;

    cdet_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (card_present),
        .level (pres_lvl),
        .rise  (pres_rise),
        .fall  (pres_fall)
    );

    // Enable half: loaded directly on a write
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= wr_data[EN_SHIFT+IRQ_HI:EN_SHIFT+IRQ_LO];
    end

    // Event sources, gated for the card-detect pair by their enables
    always_comb begin
        set_v         = '0;
        set_v[L_INS]  = pres_rise & en_q[POS_INS-IRQ_LO];
        set_v[L_REM]  = pres_fall & en_q[POS_REM-IRQ_LO];
        set_v[L_DONE] = dma_done;
        set_v[L_ERR]  = dma_err;
        set_v[L_LED]  = led_set;
    end

    // Keep mask: a written zero clears, a written one keeps
    always_comb begin
        keep_v         = '1;
        keep_v[L_INS]  = ~wr_en | wr_data[POS_INS];
        keep_v[L_REM]  = ~wr_en | wr_data[POS_REM];
        keep_v[L_DONE] = ~wr_en | wr_data[POS_DONE];
        keep_v[L_ERR]  = ~wr_en | wr_data[POS_ERR];
        keep_v[L_LED]  = ~wr_en | wr_data[POS_LED];
    end

    evt_latch #(.W(N_LATCH)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_v),
        .keep  (keep_v),
        .q     (flag_q)
    );

    // Status bits 8..14 as seen by the interrupt logic
    always_comb begin
        stat_v                   = '0;
        stat_v[POS_INS-IRQ_LO]   = flag_q[L_INS];
        stat_v[POS_REM-IRQ_LO]   = flag_q[L_REM];
        stat_v[POS_FIFO-IRQ_LO]  = fifo_empty;
        stat_v[POS_DONE-IRQ_LO]  = flag_q[L_DONE];
        stat_v[POS_ERR-IRQ_LO]   = flag_q[L_ERR];
    end

    // Read word assembly
    always_comb begin
        rd_data                                = '0;
        rd_data[POS_PRES]                      = pres_lvl;
        rd_data[IRQ_HI:IRQ_LO]                 = stat_v;
        rd_data[POS_LED]                       = flag_q[L_LED];
        rd_data[EN_SHIFT+IRQ_HI:EN_SHIFT+IRQ_LO] = en_q;
    end

    assign irq    = |(stat_v & en_q);
    assign led_on = flag_q[L_LED];
endmodule

// File: rtl/card_irq_reg_chk.sv
// Checker for card_irq_reg, attached by bind; observes ports only.
module card_irq_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        dma_done,
    input logic        dma_err,
    input logic        irq,
    input logic        led_on
);
    a_r3_insert_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[8]) |-> (rd_data[1] && !$past(rd_data[1]) && $past(rd_data[24])));
    a_r4_remove_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[9]) |-> (!rd_data[1] && $past(rd_data[1]) && $past(rd_data[25])));
    a_r5_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done |=> rd_data[11]);
    a_r5_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
        dma_err |=> rd_data[14]);
    a_r7_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[11] && !dma_done) |=> !rd_data[11]);
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[31] == 1'b0) && (rd_data[23:16] == 8'h00) && (rd_data[13:12] == 2'b00));
    a_r10_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(rd_data[14:8] & rd_data[30:24]));
    a_r11_led_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        led_on == rd_data[15]);
endmodule

bind card_irq_reg card_irq_reg_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .dma_done (dma_done),
    .dma_err  (dma_err),
    .irq      (irq),
    .led_on   (led_on)
);

// File: tb/card_irq_reg_tb_top.sv
// Self-checking bench with a behavioural per-cycle reference model.
module card_irq_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        card_present = 1'b0;
    logic        dma_done = 1'b0;
    logic        dma_err = 1'b0;
    logic        fifo_empty = 1'b0;
    logic        led_set = 1'b0;
    logic        irq;
    logic        led_on;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    card_irq_reg dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .card_present(card_present), .dma_done(dma_done),
        .dma_err(dma_err), .fifo_empty(fifo_empty), .led_set(led_set),
        .irq(irq), .led_on(led_on)
    );

    // Reference model state
    bit pin_d1, pin_d2;
    bit m_ins, m_rem, m_done, m_err, m_led;
    bit [6:0] m_en;

    // Model update at each rising edge from inputs stable since the prior edge
    always @(posedge clk) begin
        bit rise, fall, k8, k9, k11, k14, k15;
        if (!rst_n) begin
            pin_d1 = 0; pin_d2 = 0;
            m_ins = 0; m_rem = 0; m_done = 0; m_err = 0; m_led = 0; m_en = 0;
        end else begin
            rise = pin_d1 && !pin_d2;
            fall = !pin_d1 && pin_d2;
            k8  = !wr_en || wr_data[8];
            k9  = !wr_en || wr_data[9];
            k11 = !wr_en || wr_data[11];
            k14 = !wr_en || wr_data[14];
            k15 = !wr_en || wr_data[15];
            m_ins  = (m_ins && k8) || (rise && m_en[0]);
            m_rem  = (m_rem && k9) || (fall && m_en[1]);
            m_done = (m_done && k11) || dma_done;
            m_err  = (m_err && k14) || dma_err;
            m_led  = (m_led && k15) || led_set;
            if (wr_en) m_en = wr_data[30:24];
            pin_d2 = pin_d1;
            pin_d1 = card_present;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every field at the falling edge
    always @(negedge clk) begin
        logic [31:0] e;
        bit eirq;
        if (rst_n && !done) begin
            e = '0;
            e[1] = pin_d2; e[8] = m_ins; e[9] = m_rem; e[10] = fifo_empty;
            e[11] = m_done; e[14] = m_err; e[15] = m_led; e[30:24] = m_en;
            eirq = |(e[14:8] & e[30:24]);
            check("R2 present", {31'd0, rd_data[1]}, {31'd0, e[1]});
            check("R3 insert", {31'd0, rd_data[8]}, {31'd0, e[8]});
            check("R4 remove", {31'd0, rd_data[9]}, {31'd0, e[9]});
            check("R5 dma flags", {30'd0, rd_data[14], rd_data[11]}, {30'd0, e[14], e[11]});
            check("R6 fifo level", {31'd0, rd_data[10]}, {31'd0, e[10]});
            check("R7 R8 R9 word", rd_data, e);
            check("R10 irq", {31'd0, irq}, {31'd0, eirq});
            check("R11 led", {31'd0, led_on}, {31'd0, e[15]});
        end
    end

    task automatic step();
        @(posedge clk); #2;
        wr_en = 0; dma_done = 0; dma_err = 0; led_set = 0;
    endtask

    task automatic wr(logic [31:0] d);
        wr_en = 1; wr_data = d; step();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #1000000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        card_present = 1;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        // R1: reset state (pin already high but sync reset to 0)
        check("R1 reset word", rd_data, 32'h0);
        check("R1 reset irq", {31'd0, irq}, 32'd0);
        check("R1 reset led", {31'd0, led_on}, 32'd0);
        idle(4);
        // R3 disarmed: remove/reinsert with no enables
        card_present = 0; idle(4); card_present = 1; idle(4);
        // Arm insert only, then remove and insert
        wr(32'h0100_0000);
        card_present = 0; idle(4); card_present = 1; idle(4);
        // R7: write ones keeps, zero clears insert
        wr(32'h0100_FFFF); idle(1);
        wr(32'h0200_0000);
        // R4: arm removal only
        card_present = 0; idle(4); card_present = 1; idle(4);
        wr(32'h0000_0000); idle(1);
        // R5 with masks off, then enable
        dma_done = 1; step(); dma_err = 1; step(); idle(1);
        wr(32'h4800_4800); idle(1);
        wr(32'h4800_0800); idle(1);
        // R8: event together with clearing write
        dma_done = 1; wr_en = 1; wr_data = 32'h4800_0000; step(); idle(1);
        // R6: fifo level with and without enable
        fifo_empty = 1; idle(2); wr(32'h0400_0000); idle(1); fifo_empty = 0; idle(1);
        // R11: led
        led_set = 1; step(); idle(1); wr(32'h0000_8000); idle(1);
        wr(32'h0000_0000); idle(1);
        led_set = 1; wr_en = 1; wr_data = 32'h0; step(); idle(1);
        // R9: reserved bits written as ones
        wr(32'hFFFF_FFFF); idle(2);
        // Random phase
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 4) card_present = ~card_present;
            fifo_empty = ($urandom_range(0, 9) == 0) ? ~fifo_empty : fifo_empty;
            dma_done = ($urandom_range(0, 15) == 0);
            dma_err  = ($urandom_range(0, 19) == 0);
            led_set  = ($urandom_range(0, 19) == 0);
            wr_en    = ($urandom_range(0, 7) == 0);
            wr_data  = $urandom;
            @(posedge clk); #2;
        end
        wr_en = 0; dma_done = 0; dma_err = 0; led_set = 0;
        idle(3);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule